// File: doc/BRIEF.md
# Dynamic Dataless-Way Count Controller

This block chooses, once per measurement epoch, how many of the data arrays of a set-associative last-level cache to switch off at runtime. Two ways are dataless by construction. The remaining data ways, fourteen by default, can be powered down one at a time. Switching off a data way saves energy but turns some hits into misses. Software sets an upper limit on the slowdown it accepts, in units of 0.1 percent. The block picks the largest number of extra dataless ways whose predicted slowdown stays inside that limit.

During an epoch, the block takes one record per lookup from an auxiliary tag array. Each record says whether the lookup hit and, if it did, at which recency position of a full-size shadow stack. Position 0 is most recently used and position 15 is least recently used. Sixteen counters accumulate the hits per position. Turning off k data ways is modelled as losing the hits at the k least-recently-used data positions. Those lost hits become extra misses, each costing the aggregated average memory latency supplied on an input. At the end of the epoch, the block tests k = 1, 2, ... one candidate per cycle and stops at the first one that fails. It then publishes the count and a matching way mask, clears its counters and starts the next epoch.

The lookup records arrive on a valid/ready stream. A record transfers in a cycle where `acc_valid` and `acc_ready` are both high. The block lowers `acc_ready` while it evaluates candidates. A source may hold `acc_valid` and its record stable during that time; such a record is neither counted nor lost, and it transfers once `acc_ready` returns high. The bound, epoch length and latency inputs are plain control pins. The bound and latency are used during the evaluation cycles.

Top module: `dlw_way_ctrl`

## Requirements
- R1: During and after reset, `dyn_count` is 0, `way_off_mask` is all zeros, and `acc_ready` is 1.
- R2: Each transferred record with `acc_hit`=1 adds one to the hit counter of position `acc_pos`. A record with `acc_hit`=0 counts only toward the epoch length.
- R3: The extra misses predicted for k switched-off ways are the sum of the hit counters at positions 14-k through 13. Hits at positions 14 and 15 never count as extra misses.
- R4: A candidate k passes when extra_misses(k) × `avg_lat` × 1000 ≤ `cfg_bound` × epoch_cycles. Candidates are tested in increasing order from 1, evaluation stops at the first failure, and the published count is the last k that passed (0 if none did). The comparison includes equality.
- R5: When `cfg_bound` is 0, the published count is 0 whatever the hit counters hold.
- R6: The published count never exceeds 14, the number of data ways. If every candidate passes, the count is 14.
- R7: Bit i of `way_off_mask` (data way i, 0..13) is 1 exactly when i ≥ 14 − `dyn_count`, so the highest-numbered data ways are switched off first.
- R8: An epoch closes on the transfer of record number max(`cfg_epoch`, 1). epoch_cycles counts every cycle with `acc_ready` high since the previous evaluation ended (or since reset), idle cycles included, up to and including the cycle of the closing transfer.
- R9: `acc_ready` is low from the cycle after the closing transfer for exactly as many cycles as candidates are tested (1 to 14). Records offered while it is low are not counted.
- R10: All hit counters, the record count and the cycle count restart from zero after each evaluation, so each epoch's result depends only on its own records.
- R11: `dyn_count` and `way_off_mask` change only at the end of an evaluation. They hold their values while records are being collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bound | input | 10 | Allowed slowdown in 0.1 % units; 0 forces no extra ways off |
| cfg_epoch | input | 16 | Records per epoch; 0 acts as 1 |
| avg_lat | input | 16 | Aggregated average memory latency in cycles |
| acc_valid | input | 1 | A lookup record is offered |
| acc_ready | output | 1 | Block accepts a record this cycle |
| acc_hit | input | 1 | The lookup hit in the shadow tags |
| acc_pos | input | 4 | Recency position of the hit, 0 = most recent |
| dyn_count | output | 4 | Number of extra data ways switched off |
| way_off_mask | output | 14 | One bit per data way, 1 = switched off |

## Verification
The bench targets the exact-equality edge of the budget test. It does this by setting the latency after the epoch closes, so the comparison lands precisely on the limit and then one cycle above it. A strict comparison would lose a way there, and a loose one would keep a way it should drop. Other cases cover hits parked at the two least-recent positions, which must not count as losses, and a zero bound, which must give zero even when no hits would be lost. A long idle stretch before the records must enlarge the budget, so a cycle counter that ignored idle time would return 0. Finally, a record held valid through the stall must stay out of the next epoch, and the stall length must equal the number of candidates tried; a block that kept counting, or evaluated a fixed number of cycles, would show a wrong count or a wrong stall.

// File: rtl/dlw_pkg.sv
package dlw_pkg;
  // Fixed-point scale of the bound: one unit is 0.1 percent.
  localparam int BOUND_SCALE = 1000;

  typedef enum logic [0:0] {
    ST_COLLECT = 1'b0,
    ST_EVAL    = 1'b1
  } dlw_state_e;
endpackage

// File: rtl/dlw_hit_bank.sv
module dlw_hit_bank #(
  parameter int WAYS  = 16,
  parameter int CNT_W = 16,
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [POS_W-1:0] inc_pos,
  input  logic             clr,
  input  logic [POS_W-1:0] rd_idx,
  output logic [CNT_W-1:0] rd_val
);
  logic [CNT_W-1:0] cnt [WAYS];

  for (genvar i = 0; i < WAYS; i++) begin : g_pos
    logic [CNT_W-1:0] c_q;
    logic             hit_here;

    assign hit_here = inc_en && (inc_pos == POS_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        c_q <= '0;
      else if (clr)      c_q <= '0;
      else if (hit_here) c_q <= c_q + 1'b1;
    end
    assign cnt[i] = c_q;

    // R2: an epoch never holds more records than a counter can count
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_here |-> (c_q != {CNT_W{1'b1}}));
  end

  assign rd_val = cnt[rd_idx];
endmodule

// File: rtl/dlw_epoch_track.sv
module dlw_epoch_track #(
  parameter int CNT_W = 16,
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fire,
  input  logic [CNT_W-1:0] epoch_len,
  input  logic             clr,
  output logic             last,
  output logic [CYC_W-1:0] cycles
);
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] eff_len;
  logic [CYC_W-1:0] cyc_q;

  assign eff_len = (epoch_len == '0) ? CNT_W'(1) : epoch_len;
  assign last    = fire && (({1'b0, acc_q} + 1'b1) >= {1'b0, eff_len});
  assign cycles  = cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (clr)  acc_q <= '0;
    else if (fire) acc_q <= acc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         cyc_q <= '0;
    else if (clr)                       cyc_q <= '0;
    else if (run && cyc_q != '1)        cyc_q <= cyc_q + 1'b1;
  end

  // R8: the closing transfer ends collection in the next cycle
  assert_epoch_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !run);

  // R10: after a clear the cycle count restarts
  assert_cycles_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cyc_q == '0));
endmodule

// File: rtl/dlw_budget_chk.sv
module dlw_budget_chk #(
  parameter int SUM_W = 20,
  parameter int LAT_W = 16,
  parameter int BND_W = 10,
  parameter int CYC_W = 32
) (
  input  logic [SUM_W-1:0] lost,
  input  logic [LAT_W-1:0] lat,
  input  logic [BND_W-1:0] bound,
  input  logic [CYC_W-1:0] cycles,
  output logic             ok
);
  import dlw_pkg::*;

  localparam int LHS_W = SUM_W + LAT_W + 10;
  localparam int RHS_W = BND_W + CYC_W;
  localparam int CMP_W = (LHS_W > RHS_W) ? LHS_W : RHS_W;

  logic [CMP_W-1:0] cost;
  logic [CMP_W-1:0] allow;

  assign cost  = CMP_W'(lost) * CMP_W'(lat) * CMP_W'(BOUND_SCALE);
  assign allow = CMP_W'(bound) * CMP_W'(cycles);
  assign ok    = (bound != '0) && (cost <= allow);
endmodule

// File: rtl/dlw_mask_gen.sv
module dlw_mask_gen #(
  parameter int DATA_WAYS = 14,
  localparam int K_W = $clog2(DATA_WAYS + 1)
) (
  input  logic [K_W-1:0]       count,
  output logic [DATA_WAYS-1:0] mask
);
  for (genvar i = 0; i < DATA_WAYS; i++) begin : g_bit
    assign mask[i] = (int'(count) + i) >= DATA_WAYS;
  end
endmodule

// File: rtl/dlw_way_ctrl.sv
module dlw_way_ctrl #(
  parameter int WAYS        = 16,
  parameter int STATIC_WAYS = 2,
  parameter int CNT_W       = 16,
  parameter int LAT_W       = 16,
  parameter int BND_W       = 10,
  parameter int CYC_W       = 32,
  localparam int DATA_WAYS  = WAYS - STATIC_WAYS,
  localparam int POS_W      = $clog2(WAYS),
  localparam int K_W        = $clog2(DATA_WAYS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BND_W-1:0]     cfg_bound,
  input  logic [CNT_W-1:0]     cfg_epoch,
  input  logic [LAT_W-1:0]     avg_lat,
  input  logic                 acc_valid,
  output logic                 acc_ready,
  input  logic                 acc_hit,
  input  logic [POS_W-1:0]     acc_pos,
  output logic [K_W-1:0]       dyn_count,
  output logic [DATA_WAYS-1:0] way_off_mask
);
  import dlw_pkg::*;

  localparam int SUM_W = CNT_W + POS_W;
  localparam logic [K_W-1:0] MAX_K = K_W'(DATA_WAYS);

  dlw_state_e       state_q;
  logic [K_W-1:0]   k_try_q;
  logic [K_W-1:0]   best_q;
  logic [K_W-1:0]   count_q;
  logic [SUM_W-1:0] cum_q;
  logic [SUM_W-1:0] cum_next;
  logic [POS_W-1:0] rd_idx;
  logic [CNT_W-1:0] rd_val;
  logic [CYC_W-1:0] cycles;
  logic             fire;
  logic             last;
  logic             pass;
  logic             evaluating;
  logic             eval_done;

  assign acc_ready  = (state_q == ST_COLLECT);
  assign evaluating = (state_q == ST_EVAL);
  assign fire       = acc_valid && acc_ready;
  assign rd_idx     = POS_W'(DATA_WAYS) - POS_W'(k_try_q);
  assign cum_next   = cum_q + SUM_W'(rd_val);
  assign eval_done  = evaluating && (!pass || k_try_q == MAX_K);

  dlw_hit_bank #(.WAYS(WAYS), .CNT_W(CNT_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (fire && acc_hit),
    .inc_pos (acc_pos),
    .clr     (eval_done),
    .rd_idx  (rd_idx),
    .rd_val  (rd_val)
  );

  dlw_epoch_track #(.CNT_W(CNT_W), .CYC_W(CYC_W)) u_epoch (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (acc_ready),
    .fire      (fire),
    .epoch_len (cfg_epoch),
    .clr       (eval_done),
    .last      (last),
    .cycles    (cycles)
  );

  dlw_budget_chk #(.SUM_W(SUM_W), .LAT_W(LAT_W), .BND_W(BND_W), .CYC_W(CYC_W)) u_chk (
    .lost   (cum_next),
    .lat    (avg_lat),
    .bound  (cfg_bound),
    .cycles (cycles),
    .ok     (pass)
  );

  dlw_mask_gen #(.DATA_WAYS(DATA_WAYS)) u_mask (
    .count (count_q),
    .mask  (way_off_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      k_try_q <= K_W'(1);
      best_q  <= '0;
      cum_q   <= '0;
      count_q <= '0;
    end else begin
      unique case (state_q)
        ST_COLLECT: begin
          if (last) begin
            state_q <= ST_EVAL;
            k_try_q <= K_W'(1);
            best_q  <= '0;
            cum_q   <= '0;
          end
        end
        ST_EVAL: begin
          if (pass) begin
            best_q  <= k_try_q;
            cum_q   <= cum_next;
            k_try_q <= k_try_q + K_W'(1);
          end
          if (eval_done) begin
            count_q <= pass ? k_try_q : best_q;
            state_q <= ST_COLLECT;
          end
        end
        default: state_q <= ST_COLLECT;
      endcase
    end
  end

  assign dyn_count = count_q;

  // R6: the published count stays within the data ways
  assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dyn_count <= MAX_K);

  // R7: the mask built downstream carries as many ones as the count
  assert_mask_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(way_off_mask) == int'(dyn_count));

  // R11: outputs hold while collecting
  assert_hold_outputs_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ready && $past(acc_ready)) |-> $stable(dyn_count));

  // R5: a zero bound ends evaluation with a zero count
  assert_zero_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evaluating && cfg_bound == '0) |=> (dyn_count == '0));

  // R9: the closing transfer stalls the stream in the next cycle
  assert_stall_after_close_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && last) |=> !acc_ready);
endmodule

// File: tb/test_dlw_way_ctrl.sv
module test_dlw_way_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  cfg_bound = '0;
  logic [15:0] cfg_epoch = '0;
  logic [15:0] avg_lat = '0;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic        acc_hit = 1'b0;
  logic [3:0]  acc_pos = '0;
  logic [3:0]  dyn_count;
  logic [13:0] way_off_mask;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int hc [16];
  int nmiss;
  int tb_cyc = 0;

  always #5ns clk = ~clk;

  dlw_way_ctrl i_dlw_way_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_bound    (cfg_bound),
    .cfg_epoch    (cfg_epoch),
    .avg_lat      (avg_lat),
    .acc_valid    (acc_valid),
    .acc_ready    (acc_ready),
    .acc_hit      (acc_hit),
    .acc_pos      (acc_pos),
    .dyn_count    (dyn_count),
    .way_off_mask (way_off_mask)
  );

  // Epoch cycle count as defined by R8, seen from the ports only
  always @(posedge clk) begin
    if (!rst_n || !acc_ready) tb_cyc <= 0;
    else                      tb_cyc <= tb_cyc + 1;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_k(input longint lat, input longint bnd, input longint cyc, output int tries);
    longint cum;
    int best;
    cum = 0;
    best = 0;
    tries = 0;
    for (int k = 1; k <= 14; k++) begin
      tries = k;
      cum += hc[14-k];
      if (bnd != 0 && cum * lat * 1000 <= bnd * cyc) best = k;
      else break;
    end
    return best;
  endfunction

  function automatic longint model_mask(input int k);
    return ((longint'(1) << k) - 1) << (14 - k);
  endfunction

  task automatic clear_mix();
    for (int p = 0; p < 16; p++) hc[p] = 0;
    nmiss = 0;
  endtask

  // Enters and leaves at a falling edge with acc_ready high.
  task automatic run_epoch(input string req, input int len, input int lat, input int bnd,
                           input int idle, input int late_add, input bit stall_valid);
    int c;
    int tries;
    int ek;
    int st;
    longint use_lat;
    cfg_epoch = 16'(len);
    avg_lat   = 16'(lat);
    cfg_bound = 10'(bnd);
    repeat (idle) @(negedge clk);
    for (int p = 0; p < 16; p++) begin
      for (int n = 0; n < hc[p]; n++) begin
        acc_valid = 1'b1; acc_hit = 1'b1; acc_pos = 4'(p);
        @(negedge clk);
      end
    end
    for (int n = 0; n < nmiss; n++) begin
      acc_valid = 1'b1; acc_hit = 1'b0; acc_pos = 4'd0;
      @(negedge clk);
    end
    if (stall_valid) begin
      acc_valid = 1'b1; acc_hit = 1'b1; acc_pos = 4'd13;
    end else begin
      acc_valid = 1'b0;
    end
    chk("R9", "ready after closing transfer", acc_ready, 0);
    c = tb_cyc;
    use_lat = lat;
    if (late_add >= 0) begin
      use_lat = c + late_add;
      avg_lat = 16'(use_lat);
    end
    ek = model_k(use_lat, bnd, c, tries);
    st = 0;
    while (!acc_ready && st < 100) begin
      st++;
      @(negedge clk);
    end
    acc_valid = 1'b0;
    chk("R9", "stall length", st, tries);
    chk(req, "dynamic count", dyn_count, ek);
    chk("R7", "way mask", way_off_mask, model_mask(ek));
  endtask

  task automatic t_reset();
    chk("R1", "ready in reset", acc_ready, 1);
    chk("R1", "count in reset", dyn_count, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "count after reset", dyn_count, 0);
    chk("R1", "mask after reset", way_off_mask, 0);
    chk("R1", "ready after reset", acc_ready, 1);
  endtask

  task automatic t_partial();   // R2 R4: count stops at first failing candidate
    clear_mix();
    hc[0] = 20; hc[11] = 3; hc[12] = 1; hc[13] = 2; nmiss = 14;
    run_epoch("R4", 40, 5, 500, 0, -1, 1'b0);
  endtask

  task automatic t_hold();      // R11
    logic [3:0]  k0;
    logic [13:0] m0;
    int changes;
    k0 = dyn_count; m0 = way_off_mask; changes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (dyn_count != k0 || way_off_mask != m0) changes++;
    end
    chk("R11", "output changes while idle", changes, 0);
  endtask

  task automatic t_idle_budget();  // R8: idle cycles widen the budget
    clear_mix();
    hc[0] = 10; hc[10] = 5; hc[11] = 1; hc[12] = 1; hc[13] = 1; nmiss = 2;
    run_epoch("R8", 20, 20, 10, 5000, -1, 1'b0);
    chk("R8", "idle epoch keeps two ways off", dyn_count, 2);
  endtask

  task automatic t_zero_bound();   // R5
    clear_mix();
    nmiss = 8;
    run_epoch("R5", 8, 10, 0, 0, -1, 1'b0);
    chk("R5", "zero bound count", dyn_count, 0);
  endtask

  task automatic t_cap();          // R6
    clear_mix();
    nmiss = 10;
    run_epoch("R6", 10, 100, 1, 0, -1, 1'b0);
    chk("R6", "capped count", dyn_count, 14);
  endtask

  task automatic t_top_positions();  // R3
    clear_mix();
    hc[14] = 6; hc[15] = 6;
    run_epoch("R3", 12, 1000, 1, 0, -1, 1'b0);
    chk("R3", "positions 14 and 15 not lost", dyn_count, 14);
  endtask

  task automatic t_equal();        // R4: equality passes, one above fails
    clear_mix();
    hc[0] = 4; hc[12] = 5; hc[13] = 1;
    run_epoch("R4", 10, 1, 1000, 0, 0, 1'b0);
    chk("R4", "equality passes", dyn_count, 1);
    run_epoch("R4", 10, 1, 1000, 0, 1, 1'b0);
    chk("R4", "one above limit fails", dyn_count, 0);
  endtask

  task automatic t_stall_and_clear();  // R9 R10
    clear_mix();
    hc[13] = 8;
    run_epoch("R10", 8, 1000, 1, 0, -1, 1'b1);
    clear_mix();
    nmiss = 6;
    run_epoch("R10", 6, 60000, 1, 0, -1, 1'b0);
    chk("R10", "no hits carried over", dyn_count, 14);
  endtask

  task automatic t_epoch_zero();   // R8: length 0 acts as 1
    clear_mix();
    hc[13] = 1;
    run_epoch("R8", 0, 1000, 1, 0, -1, 1'b0);
    chk("R8", "single record epoch", dyn_count, 0);
    clear_mix();
    nmiss = 1;
    run_epoch("R8", 0, 1000, 1, 0, -1, 1'b0);
    chk("R8", "single miss epoch", dyn_count, 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_partial();
    t_hold();
    t_idle_budget();
    t_zero_bound();
    t_cap();
    t_top_positions();
    t_equal();
    t_stall_and_clear();
    t_epoch_zero();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1500us;
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule